// File: doc/BRIEF.md
# Processor Level-Read Sleep Sequencer

This block sits in the chipset's power-management logic. Software lowers the processor's power level by reading a level register. A strobed read at the first level address asserts the stop-clock pin, which holds the processor in its C2 (clock-stopped) state. A read at the second address starts a longer entry sequence. Stop-clock goes high first. A fixed number of cycles later, the sleep pin goes high and the processor reaches C3. When the deep option is built in, a further fixed interval later the block also gates off the processor's external clock.

A wake event, such as an interrupt or a bus-master request, ends a hold state. The pins are then released in the opposite order, with the same interval between steps. A wake event that arrives while the entry sequence is still running is held and acted on as soon as the hold state is reached. The read returns zero data. While a sequence is running, reads are ignored and a busy flag is high.

Top module: `proc_sleep_seq`

## Requirements
- R1: A strobed read at `LVL2_ADDR` while idle sets `stpclk_o` on the next cycle, and `slp_o` stays low for the whole C2 hold.
- R2: A strobed read at `LVL3_ADDR` while idle sets `stpclk_o` on the next cycle, and `slp_o` rises exactly `STEP_CYC` cycles after `stpclk_o` rose.
- R3: `slp_o` is never high while `stpclk_o` is low.
- R4: With `DEEP_EN`=1, `extclk_stop_o` rises exactly `STEP_CYC` cycles after `slp_o` rose, and it is never high while `slp_o` is low.
- R5: `wake_evt` high at a clock edge during a hold ends it. From C2, `stpclk_o` falls at that edge. From deep C3, `extclk_stop_o` falls at that edge, `slp_o` falls `STEP_CYC` cycles later, and `stpclk_o` falls `STEP_CYC` cycles after that.
- R6: With `DEEP_EN`=0, `extclk_stop_o` stays low. A wake during the C3 hold drops `slp_o` at that edge, and `stpclk_o` drops `STEP_CYC` cycles later.
- R7: `rd_data` is always zero. Strobed reads while `busy_o` is high, and reads at any other address, change nothing.
- R8: `busy_o` rises together with `stpclk_o` and falls together with it when the release sequence completes.
- R9: A wake event during the entry sequence is held and ends the hold after one cycle in it. A wake event while idle has no effect on a later read.
- R10: While reset is asserted, and after it is released, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Single-cycle read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data, always zero |
| wake_evt | input | 1 | Wake request (interrupt or bus master) |
| stpclk_o | output | 1 | Stop-clock pin toward the processor |
| slp_o | output | 1 | Sleep pin toward the processor |
| extclk_stop_o | output | 1 | External clock gate (deep step) |
| busy_o | output | 1 | Sequence in progress |

## Verification
The bench runs a C3 sequence and a C2 sequence through a deep and a non-deep instance at the same time, and checks every output cycle by cycle. A design with an off-by-one step counter would move the sleep or clock-gate edge by one cycle against the table. A design that accepted a read while busy would jump from C3 to C2, or restart its timing. Directed tests send a wake pulse during the entry sequence; a design that dropped that wake would stay asleep for good, and busy would never fall. They also send a wake while idle before a read; a design that kept that wake would leave the hold at once. A reset in the middle of a sequence must clear all pins at once.

// File: rtl/psleep_pkg.sv
package psleep_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_C2_HOLD,
      ST_C3_STOP,
      ST_C3_SLEEP,
      ST_C3_DEEP,
      ST_WK_CLK,
      ST_WK_SLEEP
   } seq_state_e;

   typedef enum logic [1:0] {
      LVL_NONE,
      LVL_C2,
      LVL_C3
   } lvl_req_e;

   typedef struct packed {
      logic stop;
      logic sleep;
      logic clk_off;
   } pin_set_t;

endpackage

// File: rtl/psleep_rd_decode.sv
module psleep_rd_decode
   import psleep_pkg::*;
#(
   parameter int unsigned        ADDR_W    = 8,
   parameter int unsigned        DATA_W    = 32,
   parameter logic [ADDR_W-1:0]  LVL2_ADDR = 8'h14,
   parameter logic [ADDR_W-1:0]  LVL3_ADDR = 8'h15
) (
   input  logic              rd_stb,
   input  logic [ADDR_W-1:0] rd_addr,
   output lvl_req_e          req,
   output logic [DATA_W-1:0] rd_data
);

   logic hit2, hit3;

   assign hit2 = rd_stb && (rd_addr == LVL2_ADDR);
   assign hit3 = rd_stb && (rd_addr == LVL3_ADDR);

   always_comb begin
      if (hit3)      req = LVL_C3;
      else if (hit2) req = LVL_C2;
      else           req = LVL_NONE;
   end

   assign rd_data = '0;

endmodule

// File: rtl/psleep_step_timer.sv
module psleep_step_timer #(
   parameter int unsigned STEP_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic done
);

   localparam int unsigned CNT_W = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

   generate
      if (STEP_CYC == 1) begin : g_single
         assign done = 1'b1;
      end else begin : g_count
         localparam logic [CNT_W-1:0] LAST = CNT_W'(STEP_CYC - 1);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (clr)           cnt_q <= '0;
            else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
         end

         assign done = (cnt_q == LAST);
      end
   endgenerate

endmodule

// File: rtl/psleep_fsm.sv
module psleep_fsm
   import psleep_pkg::*;
#(
   parameter bit DEEP_EN = 1'b1
) (
   input  logic     clk,
   input  logic     rst_n,
   input  lvl_req_e req,
   input  logic     wake_evt,
   input  logic     step_done,
   output logic     tmr_clr,
   output pin_set_t pins,
   output logic     busy
);

   seq_state_e st_q, st_d;
   logic       pend_q, pend_d;
   logic       wake_any;
   logic       in_hold;
   logic       deep_on;

   generate
      if (DEEP_EN) begin : g_deep
         assign deep_on = 1'b1;
      end else begin : g_shallow
         assign deep_on = 1'b0;
      end
   endgenerate

   function automatic pin_set_t pins_of(seq_state_e s);
      pin_set_t p;
      p.stop    = (s != ST_IDLE);
      p.sleep   = (s == ST_C3_SLEEP) || (s == ST_C3_DEEP) || (s == ST_WK_CLK);
      p.clk_off = (s == ST_C3_DEEP);
      return p;
   endfunction

   assign wake_any = wake_evt || pend_q;
   assign in_hold  = (st_q == ST_C2_HOLD) || (st_q == ST_C3_DEEP) ||
                     ((st_q == ST_C3_SLEEP) && !deep_on);

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE: begin
            if (req == LVL_C3)      st_d = ST_C3_STOP;
            else if (req == LVL_C2) st_d = ST_C2_HOLD;
         end
         ST_C2_HOLD:  if (wake_any)  st_d = ST_IDLE;
         ST_C3_STOP:  if (step_done) st_d = ST_C3_SLEEP;
         ST_C3_SLEEP: begin
            if (deep_on) begin
               if (step_done) st_d = ST_C3_DEEP;
            end else if (wake_any) begin
               st_d = ST_WK_SLEEP;
            end
         end
         ST_C3_DEEP:  if (wake_any)  st_d = ST_WK_CLK;
         ST_WK_CLK:   if (step_done) st_d = ST_WK_SLEEP;
         ST_WK_SLEEP: if (step_done) st_d = ST_IDLE;
         default:     st_d = ST_IDLE;
      endcase
   end

   always_comb begin
      if ((st_q == ST_IDLE) || (in_hold && wake_any)) pend_d = 1'b0;
      else                                             pend_d = pend_q || wake_evt;
   end

   assign tmr_clr = (st_d != st_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         pend_q <= 1'b0;
         pins   <= '0;
         busy   <= 1'b0;
      end else begin
         st_q   <= st_d;
         pend_q <= pend_d;
         pins   <= pins_of(st_d);
         busy   <= (st_d != ST_IDLE);
      end
   end

endmodule

// File: rtl/proc_sleep_seq.sv
module proc_sleep_seq
   import psleep_pkg::*;
#(
   parameter int unsigned        ADDR_W    = 8,
   parameter int unsigned        DATA_W    = 32,
   parameter logic [ADDR_W-1:0]  LVL2_ADDR = 8'h14,
   parameter logic [ADDR_W-1:0]  LVL3_ADDR = 8'h15,
   parameter int unsigned        STEP_CYC  = 3,
   parameter bit                 DEEP_EN   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_stb,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wake_evt,
   output logic              stpclk_o,
   output logic              slp_o,
   output logic              extclk_stop_o,
   output logic              busy_o
);

   generate
      if (STEP_CYC < 1) begin : g_bad_step
         $error("proc_sleep_seq: STEP_CYC must be at least 1");
      end
      if (LVL2_ADDR == LVL3_ADDR) begin : g_bad_addr
         $error("proc_sleep_seq: level addresses must differ");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("proc_sleep_seq: widths must be non-zero");
      end
   endgenerate

   lvl_req_e req;
   logic     tmr_clr;
   logic     step_done;
   pin_set_t pins;

   psleep_rd_decode #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .LVL2_ADDR (LVL2_ADDR),
      .LVL3_ADDR (LVL3_ADDR)
   ) u_dec (
      .rd_stb  (rd_stb),
      .rd_addr (rd_addr),
      .req     (req),
      .rd_data (rd_data)
   );

   psleep_step_timer #(
      .STEP_CYC (STEP_CYC)
   ) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr),
      .done  (step_done)
   );

   psleep_fsm #(
      .DEEP_EN (DEEP_EN)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .wake_evt  (wake_evt),
      .step_done (step_done),
      .tmr_clr   (tmr_clr),
      .pins      (pins),
      .busy      (busy_o)
   );

   assign stpclk_o      = pins.stop;
   assign slp_o         = pins.sleep;
   assign extclk_stop_o = pins.clk_off;

endmodule

// File: rtl/psleep_checker.sv
module psleep_checker #(
   parameter int unsigned        ADDR_W    = 8,
   parameter int unsigned        DATA_W    = 32,
   parameter logic [ADDR_W-1:0]  LVL2_ADDR = 8'h14,
   parameter bit                 DEEP_EN   = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_stb,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              wake_evt,
   input logic              stpclk_o,
   input logic              slp_o,
   input logic              extclk_stop_o,
   input logic              busy_o
);

   p_c2_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && rd_stb && rd_addr == LVL2_ADDR) |=> (stpclk_o && !slp_o));

   p_sleep_after_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(slp_o) |-> $past(stpclk_o));

   p_sleep_needs_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      slp_o |-> stpclk_o);

   p_gate_needs_sleep_r4: assert property (@(posedge clk) disable iff (!rst_n)
      extclk_stop_o |-> slp_o);

   p_gate_release_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(extclk_stop_o) |-> (slp_o && stpclk_o));

   p_stop_release_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stpclk_o) |-> !$past(slp_o));

   generate
      if (!DEEP_EN) begin : g_nodeep
         p_no_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !extclk_stop_o);
      end
   endgenerate

   p_zero_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data == '0);

   p_busy_covers_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      stpclk_o |-> busy_o);

   p_busy_falls_with_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> $fell(stpclk_o));

endmodule

bind proc_sleep_seq psleep_checker #(
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .LVL2_ADDR (LVL2_ADDR),
   .DEEP_EN   (DEEP_EN)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .rd_stb        (rd_stb),
   .rd_addr       (rd_addr),
   .rd_data       (rd_data),
   .wake_evt      (wake_evt),
   .stpclk_o      (stpclk_o),
   .slp_o         (slp_o),
   .extclk_stop_o (extclk_stop_o),
   .busy_o        (busy_o)
);

// File: tb/proc_sleep_seq_test.sv
module proc_sleep_seq_test;

   localparam int unsigned       ADDR_W = 8;
   localparam int unsigned       DATA_W = 32;
   localparam logic [ADDR_W-1:0] A_L2   = 8'h14;
   localparam logic [ADDR_W-1:0] A_L3   = 8'h15;
   localparam logic [ADDR_W-1:0] A_OTH  = 8'h20;
   localparam int unsigned       STEP   = 2;

   // entry: [11] strobe, [10:9] addr select (1 L2, 2 L3, 3 other),
   // [8] wake, [7:4] deep {stp,slp,gate,busy}, [3:0] non-deep same.
   localparam int NV = 19;
   localparam logic [11:0] VEC [0:NV-1] = '{
      12'b0_00_0_0000_0000,
      12'b1_10_0_1001_1001,   // C3 read (R2)
      12'b0_00_0_1001_1001,
      12'b0_00_0_1101_1101,
      12'b0_00_0_1101_1101,
      12'b1_01_0_1111_1101,   // read while busy (R7), gate on (R4)
      12'b0_00_0_1111_1101,
      12'b0_00_1_1101_1001,   // wake (R5, R6)
      12'b0_00_0_1101_1001,
      12'b0_00_0_1001_0000,
      12'b0_00_0_1001_0000,
      12'b0_00_0_0000_0000,
      12'b1_01_0_1001_1001,   // C2 read (R1)
      12'b1_10_0_1001_1001,   // C3 read during C2 ignored (R7)
      12'b0_00_0_1001_1001,
      12'b0_00_1_0000_0000,   // C2 wake (R5)
      12'b1_11_0_0000_0000,   // other address (R7)
      12'b0_00_1_0000_0000,
      12'b0_00_0_0000_0000
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rd_stb = 1'b0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic              wake_evt = 1'b0;
   logic [DATA_W-1:0] rd_data, rd_data_nd;
   logic              stp, slp, gate, busy;
   logic              stp_nd, slp_nd, gate_nd, busy_nd;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   proc_sleep_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL2_ADDR(A_L2),
                    .LVL3_ADDR(A_L3), .STEP_CYC(STEP), .DEEP_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
      .rd_data(rd_data), .wake_evt(wake_evt), .stpclk_o(stp), .slp_o(slp),
      .extclk_stop_o(gate), .busy_o(busy));

   proc_sleep_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL2_ADDR(A_L2),
                    .LVL3_ADDR(A_L3), .STEP_CYC(STEP), .DEEP_EN(1'b0)) uut_nd (
      .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
      .rd_data(rd_data_nd), .wake_evt(wake_evt), .stpclk_o(stp_nd), .slp_o(slp_nd),
      .extclk_stop_o(gate_nd), .busy_o(busy_nd));

   task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   task automatic drive(input logic stb, input logic [1:0] sel, input logic wk);
      rd_stb   = stb;
      wake_evt = wk;
      case (sel)
         2'd1:    rd_addr = A_L2;
         2'd2:    rd_addr = A_L3;
         2'd3:    rd_addr = A_OTH;
         default: rd_addr = '0;
      endcase
      @(posedge clk);
      @(negedge clk);
      rd_stb   = 1'b0;
      wake_evt = 1'b0;
   endtask

   initial begin
      #1000000;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      check("R10 reset deep", {stp, slp, gate, busy}, 4'b0000);
      check("R10 reset non-deep", {stp_nd, slp_nd, gate_nd, busy_nd}, 4'b0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10 after release", {stp, slp, gate, busy}, 4'b0000);

      // table walk: R1 R2 R3 R4 R5 R6 R7 R8
      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][11], VEC[i][10:9], VEC[i][8]);
         check($sformatf("R2/R4/R5/R7/R8 deep step %0d", i),
               {stp, slp, gate, busy}, VEC[i][7:4]);
         check($sformatf("R1/R3/R6/R7/R8 non-deep step %0d", i),
               {stp_nd, slp_nd, gate_nd, busy_nd}, VEC[i][3:0]);
         check("R7 read data zero", {3'b000, |{rd_data, rd_data_nd}}, 4'b0000);
      end

      // R9: wake during entry is held
      drive(1'b1, 2'd2, 1'b0);              // k = 1 after this edge set
      for (int k = 1; k <= 10; k++) begin
         if (k > 1) drive(1'b0, 2'd0, (k == 2));
         check($sformatf("R9 deep k=%0d", k), {3'b000, gate, 2'b00, busy} [3:0] == 4'b0 ?
               {2'b00, gate, busy} : {2'b00, gate, busy},
               {2'b00, (k == 5), (k <= 9)});
         check($sformatf("R9 non-deep k=%0d", k), {2'b00, slp_nd, busy_nd},
               {2'b00, (k == 3), (k <= 5)});
      end

      // R9: wake while idle is not remembered
      drive(1'b0, 2'd0, 1'b1);
      drive(1'b1, 2'd1, 1'b0);
      drive(1'b0, 2'd0, 1'b0);
      check("R9 idle wake dropped", {stp, slp, gate, busy}, 4'b1001);
      drive(1'b0, 2'd0, 1'b1);
      check("R5 C2 release", {stp, slp, gate, busy}, 4'b0000);

      // R10: reset in the middle of a C3 hold
      drive(1'b1, 2'd2, 1'b0);
      repeat (5) drive(1'b0, 2'd0, 1'b0);
      check("R4 deep hold before reset", {stp, slp, gate, busy}, 4'b1111);
      rst_n = 1'b0;
      #1;
      check("R10 mid-sequence reset", {stp, slp, gate, busy}, 4'b0000);
      check("R10 mid-sequence reset nd", {stp_nd, slp_nd, gate_nd, busy_nd}, 4'b0000);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      summary();
      $finish;
   end

endmodule